// File: doc/BRIEF.md
# Prioritised Interrupt Controller

This block gathers eight level-sensitive interrupt request lines and passes at most one of them to a processor through a single interrupt output. A software-written mask decides which lines may take part. Among the allowed pending lines, the lowest-numbered line always wins. A line is allowed only if it outranks everything that is currently in service. When the processor pulls the active-low acknowledge input low, the block drops the interrupt output. It then presents an 8-bit vector on its vector output. The vector is the programmed base plus the winning line number. The block also marks that line as in service.

Software reaches the block through a small register port with a chip-select, a write strobe and a one-bit address. Address 0 is the command address. Address 1 is the data address. Writing 0x20 to the command address ends the service of the highest-priority line in service. Writing 0x10 to the command address arms a base load, so the next data-address write sets the vector base instead of the mask. The block has two state machines. The handshake machine has the states HS_IDLE, HS_REQ and HS_ACK, with these transitions:
- raise: HS_IDLE to HS_REQ
- withdraw: HS_REQ to HS_IDLE
- accept: HS_REQ to HS_ACK
- release: HS_ACK to HS_IDLE

The configuration machine has the states CFG_RUN and CFG_ARMED, with these transitions:
- arm: CFG_RUN to CFG_ARMED, on the 0x10 command
- load: CFG_ARMED to CFG_RUN, on the next data write

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF at address 1, the in-service register reads 0x00 at address 0, the vector base is 0x00, `int_o` is low and `vec_o` is zero.
- R2: A data-address write with no base load armed sets the mask, which reads back at address 1. Mask bit n set to 1 blocks line n, and set to 0 allows it. For example, 0x7E allows lines 0 and 7 only.
- R3: `int_o` is high only while an unmasked request is pending that outranks every line in service. It rises on the second rising edge after the request line goes high, because the request is first registered and then the handshake state is updated.
- R4: Among the candidates, the lowest-numbered line wins. Line 0 ranks highest and line 7 lowest.
- R5: In HS_REQ, an edge that samples `inta_n` low moves the block to HS_ACK (accept). From that edge `int_o` is low, the winning line's bit is set in the in-service register, and `vec_o` equals base plus line number, modulo 256.
- R6: The vector is captured at accept. Request or base changes while `inta_n` stays low do not alter `vec_o`.
- R7: `vec_o` is zero whenever `inta_n` is high or the block is not in HS_ACK.
- R8: Writing 0x20 to address 0 clears the lowest-numbered set bit of the in-service register. The in-service register reads back at address 0, with bit n meaning line n is in service.
- R9: A line in service, and every lower-priority line, cannot raise `int_o` again until an end-of-interrupt clears that line, even if its request stays high.
- R10: A higher-priority request may nest over a lower-priority line that is in service.
- R11: Writing 0x10 to address 0 arms a base load, and the next address-1 write loads the base and leaves the mask unchanged. Other command values except 0x20 have no effect.
- R12: If every candidate is withdrawn while in HS_REQ, the block returns to HS_IDLE and `int_o` falls on the second edge after the request drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 8 | Level-sensitive request lines, bit n is line n |
| cs | input | 1 | Register port chip-select |
| wr | input | 1 | Register port write strobe |
| addr | input | 1 | 0 = command address, 1 = data address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Read data: in-service at address 0, mask at address 1, zero without cs |
| inta_n | input | 1 | Active-low acknowledge from the processor |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector code, valid only during acknowledge |

## Verification
The bench builds the block with its default parameters: eight lines, 8-bit data, end-of-interrupt code 0x20 and base-load code 0x10. These values make every line and the full 8-bit vector range reachable, including a base of 0x50 with line 7. The stimulus covers these cases:
- masking and unmasking of individual lines
- two lines requesting at once
- a request that changes in the middle of an acknowledge pulse
- nesting of line 0 over line 3
- a request held high through its own service
- a withdrawn request
- an unknown command code followed by a real base reload

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_REQ  = 2'd1,
        HS_ACK  = 2'd2
    } hs_state_e;

    typedef enum logic {
        CFG_RUN   = 1'b0,
        CFG_ARMED = 1'b1
    } cfg_state_e;

endpackage

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
    parameter int N  = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);

    // Lowest index wins: scan from the top so the last hit is the lowest.
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                any_o = 1'b1;
                idx_o = IW'(i);
            end
        end
    end

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int          N         = 8,
    parameter int          DW        = 8,
    parameter logic [7:0]  EOI_CODE  = 8'h20,
    parameter logic [7:0]  INIT_CODE = 8'h10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          wr,
    input  logic          addr,
    input  logic [DW-1:0] wdata,
    input  logic [N-1:0]  isr_i,
    output logic [N-1:0]  mask_o,
    output logic [DW-1:0] base_o,
    output logic          eoi_o,
    output logic [DW-1:0] rdata
);

    cfg_state_e cfg_q, cfg_d;
    logic       cmd_wr, dat_wr;

    assign cmd_wr = cs && wr && !addr;
    assign dat_wr = cs && wr && addr;
    assign eoi_o  = cmd_wr && (wdata == DW'(EOI_CODE));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RUN;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        cfg_d = cfg_q;
        unique case (cfg_q)
            CFG_RUN:   if (cmd_wr && wdata == DW'(INIT_CODE)) cfg_d = CFG_ARMED; // arm
            CFG_ARMED: if (dat_wr) cfg_d = CFG_RUN;                             // load
            default:   cfg_d = CFG_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_o <= '1;
            base_o <= '0;
        end else if (dat_wr) begin
            if (cfg_q == CFG_ARMED) base_o <= wdata;
            else                    mask_o <= wdata[N-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (cs) rdata = addr ? DW'(mask_o) : DW'(isr_i);
    end

endmodule

// File: rtl/irqc_hs.sv
module irqc_hs
    import irqc_pkg::*;
#(
    parameter int N  = 8,
    parameter int DW = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_req,
    input  logic [N-1:0]  mask_i,
    input  logic [DW-1:0] base_i,
    input  logic          eoi_i,
    input  logic          inta_n,
    output logic          int_o,
    output logic [DW-1:0] vec_o,
    output logic [N-1:0]  req_o,
    output logic [N-1:0]  isr_o,
    output hs_state_e     state_o
);

    hs_state_e     st_q, st_d;
    logic [N-1:0]  req_q, isr_q, allow, cand, isr_clr, isr_set;
    logic [DW-1:0] vec_q;
    logic          isr_any, cand_any, capture;
    logic [IW-1:0] isr_idx, win_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= irq_req;
    end

    irqc_prio_enc #(.N(N)) u_isr_enc (
        .vec_i (isr_q),
        .any_o (isr_any),
        .idx_o (isr_idx)
    );

    // Only lines strictly above the highest in-service line may compete.
    for (genvar g = 0; g < N; g++) begin : g_allow
        assign allow[g] = !isr_any || (IW'(g) < isr_idx);
    end

    assign cand = req_q & ~mask_i & allow;

    irqc_prio_enc #(.N(N)) u_win_enc (
        .vec_i (cand),
        .any_o (cand_any),
        .idx_o (win_idx)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= HS_IDLE;
        else        st_q <= st_d;
    end

    // Next state
    always_comb begin
        st_d    = st_q;
        capture = 1'b0;
        unique case (st_q)
            HS_IDLE: if (cand_any) st_d = HS_REQ;      // raise
            HS_REQ: begin
                if (!cand_any) st_d = HS_IDLE;         // withdraw
                else if (!inta_n) begin
                    st_d    = HS_ACK;                  // accept
                    capture = 1'b1;
                end
            end
            HS_ACK:  if (inta_n) st_d = HS_IDLE;       // release
            default: st_d = HS_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        int_o = (st_q == HS_REQ);
        vec_o = (st_q == HS_ACK && !inta_n) ? vec_q : '0;
    end

    assign isr_clr = (eoi_i && isr_any) ? (N'(1) << isr_idx) : '0;
    assign isr_set = capture ? (N'(1) << win_idx) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            isr_q <= '0;
            vec_q <= '0;
        end else begin
            isr_q <= (isr_q & ~isr_clr) | isr_set;
            if (capture) vec_q <= base_i + DW'(win_idx);
        end
    end

    assign req_o   = req_q;
    assign isr_o   = isr_q;
    assign state_o = st_q;

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int         N_LINES   = 8,
    parameter int         DW        = 8,
    parameter logic [7:0] EOI_CODE  = 8'h20,
    parameter logic [7:0] INIT_CODE = 8'h10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_req,
    input  logic               cs,
    input  logic               wr,
    input  logic               addr,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata,
    input  logic               inta_n,
    output logic               int_o,
    output logic [DW-1:0]      vec_o
);

    logic [N_LINES-1:0] mask_q, isr_q, req_q;
    logic [DW-1:0]      base_q;
    logic               eoi;
    hs_state_e          hs_state;

    irqc_regs #(
        .N(N_LINES), .DW(DW), .EOI_CODE(EOI_CODE), .INIT_CODE(INIT_CODE)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs     (cs),
        .wr     (wr),
        .addr   (addr),
        .wdata  (wdata),
        .isr_i  (isr_q),
        .mask_o (mask_q),
        .base_o (base_q),
        .eoi_o  (eoi),
        .rdata  (rdata)
    );

    irqc_hs #(.N(N_LINES), .DW(DW)) u_hs (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_req (irq_req),
        .mask_i  (mask_q),
        .base_i  (base_q),
        .eoi_i   (eoi),
        .inta_n  (inta_n),
        .int_o   (int_o),
        .vec_o   (vec_o),
        .req_o   (req_q),
        .isr_o   (isr_q),
        .state_o (hs_state)
    );

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
#(
    parameter int N  = 8,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          inta_n,
    input logic          int_o,
    input logic [DW-1:0] vec_o,
    input logic [N-1:0]  req_q,
    input logic [N-1:0]  mask_q,
    input logic [N-1:0]  isr_q,
    input hs_state_e     hs_state
);

    AST_INT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> $past(|(req_q & ~mask_q)));                                   // R3

    AST_INT_DROPS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (int_o && !inta_n) |=> !int_o);                                         // R5

    AST_ONE_LINE_PER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(isr_q & ~$past(isr_q)) <= 1);                                // R5

    AST_VEC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_state == HS_ACK && $past(hs_state == HS_ACK) && !inta_n && $past(!inta_n))
        |-> $stable(vec_o));                                                    // R6

    AST_VEC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        inta_n |-> (vec_o == '0));                                              // R7

endmodule

bind prio_irq_ctrl irqc_chk #(.N(N_LINES), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .inta_n   (inta_n),
    .int_o    (int_o),
    .vec_o    (vec_o),
    .req_q    (req_q),
    .mask_q   (mask_q),
    .isr_q    (isr_q),
    .hs_state (hs_state)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq = 8'h00;
    logic       cs = 1'b0, wr = 1'b0, addr = 1'b0, inta_n = 1'b1;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata, vec_o;
    logic       int_o;

    int  nvec = 0, nerr = 0;
    bit  done = 0;

    always #10 clk = ~clk;  // 50 MHz

    prio_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq), .cs(cs), .wr(wr),
        .addr(addr), .wdata(wdata), .rdata(rdata), .inta_n(inta_n),
        .int_o(int_o), .vec_o(vec_o)
    );

    // Behavioural reference model: 0 idle, 1 requesting, 2 acknowledging
    logic [7:0] m_req, m_mask, m_base, m_isr, m_vec;
    int         m_state;
    bit         m_arm;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_req = 0; m_mask = 8'hFF; m_base = 0; m_isr = 0; m_vec = 0;
            m_state = 0; m_arm = 0;
        end else begin
            int top, w, clr;
            int nstate;
            logic [7:0] nisr;
            top = 8; w = -1; clr = -1;
            for (int i = 7; i >= 0; i--) if (m_isr[i]) top = i;
            for (int i = 7; i >= 0; i--) if (i < top && m_req[i] && !m_mask[i]) w = i;
            clr = (top < 8) ? top : -1;
            nstate = m_state;
            nisr = m_isr;
            if (cs && wr && !addr && wdata == 8'h20 && clr >= 0) nisr[clr] = 1'b0;
            case (m_state)
                0: if (w >= 0) nstate = 1;
                1: if (w < 0) nstate = 0;
                   else if (!inta_n) begin
                       nstate = 2; nisr[w] = 1'b1; m_vec = m_base + 8'(w);
                   end
                default: if (inta_n) nstate = 0;
            endcase
            if (cs && wr && addr) begin
                if (m_arm) begin m_base = wdata; m_arm = 0; end
                else m_mask = wdata;
            end else if (cs && wr && !addr && wdata == 8'h10) m_arm = 1;
            m_isr = nisr;
            m_state = nstate;
            m_req = irq;
        end
    end

    task automatic compare();
        logic [7:0] ev, er;
        logic ei;
        if (!rst_n) return;
        ei = (m_state == 1);
        ev = (m_state == 2 && !inta_n) ? m_vec : 8'h00;
        er = cs ? (addr ? m_mask : m_isr) : 8'h00;
        nvec++;
        if (int_o !== ei) begin nerr++; $display("FAIL R3 int_o got %0b exp %0b", int_o, ei); end
        if (vec_o !== ev) begin nerr++; $display("FAIL R5 vec_o got %02h exp %02h", vec_o, ev); end
        if (rdata !== er) begin nerr++; $display("FAIL R8 rdata got %02h exp %02h", rdata, er); end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s got %02h exp %02h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(logic a, logic [7:0] d);
        cs = 1; wr = 1; addr = a; wdata = d;
        tick();
        cs = 0; wr = 0; wdata = 0;
    endtask

    task automatic rd_chk(logic a, logic [7:0] exp, string tag);
        cs = 1; wr = 0; addr = a;
        #1;
        chk(tag, rdata, exp);
        cs = 0;
    endtask

    task automatic wait_int();
        for (int k = 0; k < 6; k++) begin
            if (int_o) break;
            tick();
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        tick();
        chk("R1 int_o", {7'd0, int_o}, 8'h00);
        chk("R1 vec_o", vec_o, 8'h00);
        rd_chk(1'b1, 8'hFF, "R1 mask");
        rd_chk(1'b0, 8'h00, "R1 isr");

        wr_reg(0, 8'h10); wr_reg(1, 8'h20);          // base 0x20
        wr_reg(1, 8'h7E);
        rd_chk(1'b1, 8'h7E, "R2 mask readback");
        irq = 8'h10; repeat (4) tick();
        chk("R2 line4 blocked", {7'd0, int_o}, 8'h00);
        irq = 8'h01; tick(); tick();
        chk("R2 line0 allowed", {7'd0, int_o}, 8'h01);
        irq = 8'h00; tick(); tick();
        chk("R12 withdrawn", {7'd0, int_o}, 8'h00);

        wr_reg(1, 8'h00);
        irq = 8'h18; tick(); tick();
        chk("R3 raise", {7'd0, int_o}, 8'h01);
        inta_n = 0; tick();
        chk("R5 int low on ack", {7'd0, int_o}, 8'h00);
        chk("R4 lines 3,4 -> 3", vec_o, 8'h23);
        irq = 8'h01; tick();
        chk("R6 frozen vector", vec_o, 8'h23);
        inta_n = 1; #1;
        chk("R7 vec idle", vec_o, 8'h00);
        tick(); tick();
        chk("R10 nest line0", {7'd0, int_o}, 8'h01);
        inta_n = 0; tick();
        chk("R10 nest vector", vec_o, 8'h20);
        inta_n = 1; tick();
        rd_chk(1'b0, 8'h09, "R8 isr two lines");

        irq = 8'h08; repeat (3) tick();
        chk("R9 line3 held", {7'd0, int_o}, 8'h00);
        wr_reg(0, 8'h20);
        rd_chk(1'b0, 8'h08, "R8 eoi clears line0");
        repeat (4) tick();
        chk("R9 still held", {7'd0, int_o}, 8'h00);
        wr_reg(0, 8'h20);
        rd_chk(1'b0, 8'h00, "R8 eoi clears line3");
        tick();
        chk("R9 re-raise after eoi", {7'd0, int_o}, 8'h01);
        inta_n = 0; tick();
        chk("R4 line3 again", vec_o, 8'h23);
        inta_n = 1; tick();
        irq = 8'h00;
        wr_reg(0, 8'h20);

        wr_reg(0, 8'h55); wr_reg(1, 8'h00);
        rd_chk(1'b1, 8'h00, "R11 unknown cmd ignored");
        irq = 8'h80; tick(); tick();
        chk("R3 line7 raise", {7'd0, int_o}, 8'h01);
        inta_n = 0; tick();
        chk("R11 base kept", vec_o, 8'h27);
        inta_n = 1; tick();
        wr_reg(0, 8'h20);
        wr_reg(0, 8'h10); wr_reg(1, 8'h50);
        rd_chk(1'b1, 8'h00, "R11 mask untouched by base load");
        wait_int();
        inta_n = 0; tick();
        chk("R11 new base", vec_o, 8'h57);
        inta_n = 1; tick();
        wr_reg(0, 8'h20);
        irq = 8'hC0; tick();
        wait_int();
        inta_n = 0; tick();
        chk("R4 lines 6,7 -> 6", vec_o, 8'h56);
        inta_n = 1; tick();
        irq = 8'h00;
        wr_reg(0, 8'h20);
        repeat (3) tick();

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1;
            nerr++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

endmodule